// File: doc/BRIEF.md
# Scaled Memory Address Generator

This block forms the 64-bit effective address of a memory operand, or the target of a direct jump or call, from the instruction pointer, a base register value, an index register value and a displacement taken from the instruction. The displacement arrives as a 32-bit raw field plus a width flag. When the flag selects the short form, only the low eight bits are used. A two-bit mode picks the address formula. A size code gives the operand width in bytes, which scales short displacements and, in one mode, the index.

A decode or issue stage presents one request per cycle with `in_valid`. The sum is registered, so the address appears one cycle later with `out_valid`. When `in_valid` is low, the previous address is held. All arithmetic wraps modulo 2^64, and no carry or overflow is reported.

Top module: `scaled_agen`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `out_valid` is 0 and `addr` is 0.
- R2: `out_valid` equals `in_valid` from the previous clock. `addr` loads a new result only on a clock where `in_valid` is 1 and otherwise holds its value.
- R3: With `disp_wide`=1, the offset is `disp[31:0]` sign-extended to 64 bits. With `disp_wide`=0, the offset is `disp[7:0]` sign-extended, and `disp[31:8]` has no effect.
- R4: In modes 01, 10 and 11, a short (8-bit) offset is shifted left by log2 of the operand size in bytes. A 32-bit offset is never shifted.
- R5: Mode 00 (`mode`=2'b00) gives `ip + index + sext(disp[31:0])`, unscaled, whatever the value of `disp_wide`. When `index_id` is 31, the index term is 0.
- R6: Mode 01 gives `base + offset`. The index is not used.
- R7: Mode 10 gives `base + index + offset`. `index_id` = 31 does not remove the index in this mode.
- R8: Mode 11 gives `base + (index << s) + offset`, where s is log2 of the operand size in bytes.
- R9: `size_code` 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. Codes 4 to 7 all mean 16 bytes.
- R10: With `branch`=1, the result is `ip + (offset << 2)`, where the offset is the sign-extended 8- or 32-bit displacement selected by `disp_wide`. `mode`, `base`, `index`, `index_id` and `size_code` have no effect.
- R11: Every sum wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| ip | input | 64 | Instruction pointer |
| base | input | 64 | Base register value |
| index | input | 64 | Index register value |
| index_id | input | 5 | Register number of the index (31 means none in mode 00) |
| disp | input | 32 | Raw displacement field |
| disp_wide | input | 1 | 1: 32-bit displacement, 0: 8-bit displacement |
| mode | input | 2 | Addressing mode |
| size_code | input | 3 | Operand size code |
| branch | input | 1 | Compute a direct branch target |
| out_valid | output | 1 | Address valid |
| addr | output | 64 | Effective address |

## Verification
The bound checker watches the handshake and reset on every cycle. On each cycle it also checks the formulas that map directly from ports to the result: the wide-offset branch target, mode 01 with a wide offset, mode 00 with no index, and the hold of `addr` when no request is present. The scaling of short offsets and of the index for every size code, the fact that the upper displacement bits are ignored, the fact that register 31 is still used as an index outside mode 00, and wraparound near 2^64 can only be shown by the bench. It does this with directed corner requests and seeded random requests, each compared with a reference function.

// File: rtl/agen_pkg.sv
package agen_pkg;
  localparam int ADDR_W   = 64;
  localparam int DISP_W   = 32;
  localparam int SHORT_W  = 8;
  localparam int SIZE_W   = 3;
  localparam int REGID_W  = 5;
  localparam int SHIFT_W  = 3;

  typedef enum logic [1:0] {
    AM_IP_INDEX  = 2'b00,
    AM_BASE      = 2'b01,
    AM_BASE_IDX  = 2'b10,
    AM_BASE_SIDX = 2'b11
  } amode_e;

  // log2 of operand bytes; codes above 4 saturate at 16 bytes
  function automatic logic [SHIFT_W-1:0] size_shift(input logic [SIZE_W-1:0] code);
    if (code >= SIZE_W'(4)) return SHIFT_W'(4);
    else                    return SHIFT_W'(code);
  endfunction
endpackage

// File: rtl/agen_offset.sv
module agen_offset
  import agen_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DISP_W,
  parameter int SW = SHORT_W,
  parameter int HW = SHIFT_W
) (
  input  logic [DW-1:0] disp,
  input  logic          use_wide,
  input  logic [HW-1:0] shamt,
  output logic [AW-1:0] offset
);
  localparam int WIDE_PAD  = AW - DW;
  localparam int SHORT_PAD = AW - SW;

  logic [AW-1:0] ext_wide;
  logic [AW-1:0] ext_short;

  always_comb begin
    ext_wide  = {{WIDE_PAD{disp[DW-1]}}, disp};
    ext_short = {{SHORT_PAD{disp[SW-1]}}, disp[SW-1:0]};
    offset    = (use_wide ? ext_wide : ext_short) << shamt;
  end
endmodule

// File: rtl/agen_index.sv
module agen_index
  import agen_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int RW = REGID_W,
  parameter int HW = SHIFT_W,
  parameter logic [RW-1:0] NONE_ID = '1
) (
  input  logic [AW-1:0] index,
  input  logic [RW-1:0] index_id,
  input  logic [1:0]    mode,
  input  logic [HW-1:0] size_sh,
  output logic [AW-1:0] term
);
  always_comb begin
    unique case (amode_e'(mode))
      AM_IP_INDEX:  term = (index_id == NONE_ID) ? '0 : index;
      AM_BASE:      term = '0;
      AM_BASE_IDX:  term = index;
      AM_BASE_SIDX: term = index << size_sh;
      default:      term = '0;
    endcase
  end
endmodule

// File: rtl/scaled_agen.sv
module scaled_agen
  import agen_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DISP_W,
  parameter int SW = SHORT_W,
  parameter int ZW = SIZE_W,
  parameter int RW = REGID_W,
  parameter int BRANCH_SH = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [AW-1:0] ip,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] index,
  input  logic [RW-1:0] index_id,
  input  logic [DW-1:0] disp,
  input  logic          disp_wide,
  input  logic [1:0]    mode,
  input  logic [ZW-1:0] size_code,
  input  logic          branch,
  output logic          out_valid,
  output logic [AW-1:0] addr
);
  localparam int HW = SHIFT_W;

  logic [HW-1:0] size_sh;
  logic [HW-1:0] off_sh;
  logic          off_wide;
  logic          ip_rel;
  logic [AW-1:0] offset;
  logic [AW-1:0] idx_term;
  logic [AW-1:0] anchor;
  logic [AW-1:0] sum;

  always_comb begin
    size_sh  = size_shift(size_code);
    ip_rel   = (amode_e'(mode) == AM_IP_INDEX);
    if (branch) begin
      off_wide = disp_wide;
      off_sh   = HW'(BRANCH_SH);
    end else if (ip_rel) begin
      off_wide = 1'b1;
      off_sh   = '0;
    end else begin
      off_wide = disp_wide;
      off_sh   = disp_wide ? '0 : size_sh;
    end
    anchor = (branch || ip_rel) ? ip : base;
  end

  agen_offset #(.AW(AW), .DW(DW), .SW(SW), .HW(HW)) u_offset (
    .disp     (disp),
    .use_wide (off_wide),
    .shamt    (off_sh),
    .offset   (offset)
  );

  logic [AW-1:0] idx_raw;

  agen_index #(.AW(AW), .RW(RW), .HW(HW)) u_index (
    .index    (index),
    .index_id (index_id),
    .mode     (mode),
    .size_sh  (size_sh),
    .term     (idx_raw)
  );

  always_comb begin
    idx_term = branch ? '0 : idx_raw;
    sum      = anchor + idx_term + offset;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      addr      <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) addr <= sum;
    end
  end
endmodule

// File: rtl/scaled_agen_chk.sv
module scaled_agen_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [63:0] ip,
  input logic [63:0] base,
  input logic [4:0]  index_id,
  input logic [31:0] disp,
  input logic        disp_wide,
  input logic [1:0]  mode,
  input logic        branch,
  input logic        out_valid,
  input logic [63:0] addr
);
  logic [63:0] wide_ext;
  assign wide_ext = {{32{disp[31]}}, disp};

  // R1
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (!out_valid && addr == 64'd0));
  // R2
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);
  a_r2_idle_no_valid: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid);
  a_r2_hold_addr: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(addr));
  // R10
  a_r10_branch_wide: assert property (@(posedge clk) disable iff (rst)
    (in_valid && branch && disp_wide) |=> addr == $past(ip) + ($past(wide_ext) << 2));
  // R6
  a_r6_base_wide: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !branch && mode == 2'b01 && disp_wide) |=> addr == $past(base) + $past(wide_ext));
  // R5
  a_r5_ip_no_index: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !branch && mode == 2'b00 && index_id == 5'd31) |=> addr == $past(ip) + $past(wide_ext));
endmodule

bind scaled_agen scaled_agen_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .ip(ip), .base(base),
  .index_id(index_id), .disp(disp), .disp_wide(disp_wide), .mode(mode),
  .branch(branch), .out_valid(out_valid), .addr(addr)
);

// File: tb/scaled_agen_tb.sv
module scaled_agen_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [63:0] ip, base, index;
  logic [4:0]  index_id;
  logic [31:0] disp;
  logic        disp_wide;
  logic [1:0]  mode;
  logic [2:0]  size_code;
  logic        branch;
  logic        out_valid;
  logic [63:0] addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  scaled_agen dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .ip(ip), .base(base), .index(index),
    .index_id(index_id), .disp(disp), .disp_wide(disp_wide), .mode(mode),
    .size_code(size_code), .branch(branch), .out_valid(out_valid), .addr(addr)
  );

  function automatic int unsigned sz_log(input logic [2:0] c);
    return (c >= 3'd4) ? 4 : int'(c);
  endfunction

  function automatic logic [63:0] model(
    input logic [63:0] f_ip, f_base, f_idx, input logic [4:0] f_id,
    input logic [31:0] f_disp, input logic f_wide, input logic [1:0] f_mode,
    input logic [2:0] f_sz, input logic f_br);
    logic [63:0] o32, o8;
    o32 = {{32{f_disp[31]}}, f_disp};
    o8  = {{56{f_disp[7]}}, f_disp[7:0]};
    if (f_br) return f_ip + ((f_wide ? o32 : o8) << 2);
    case (f_mode)
      2'b00: return f_ip + ((f_id == 5'd31) ? 64'd0 : f_idx) + o32;
      2'b01: return f_base + (f_wide ? o32 : (o8 << sz_log(f_sz)));
      2'b10: return f_base + f_idx + (f_wide ? o32 : (o8 << sz_log(f_sz)));
      default: return f_base + (f_idx << sz_log(f_sz)) + (f_wide ? o32 : (o8 << sz_log(f_sz)));
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input string req, input logic [63:0] a_ip, a_base, a_idx,
                       input logic [4:0] a_id, input logic [31:0] a_disp, input logic a_wide,
                       input logic [1:0] a_mode, input logic [2:0] a_sz, input logic a_br);
    logic [63:0] e;
    ip = a_ip; base = a_base; index = a_idx; index_id = a_id; disp = a_disp;
    disp_wide = a_wide; mode = a_mode; size_code = a_sz; branch = a_br; in_valid = 1'b1;
    e = model(a_ip, a_base, a_idx, a_id, a_disp, a_wide, a_mode, a_sz, a_br);
    @(negedge clk);
    chk({req, " valid"}, {63'd0, out_valid}, 64'd1);
    chk(req, addr, e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    int unsigned seed;
    seed = 32'h1234_5a5a;
    void'($urandom(seed));
    rst = 1'b1; in_valid = 1'b0; ip = '0; base = '0; index = '0; index_id = '0;
    disp = '0; disp_wide = 1'b0; mode = '0; size_code = '0; branch = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 addr", addr, 64'd0);
    chk("R1 valid", {63'd0, out_valid}, 64'd0);
    rst = 1'b0;

    // R3: upper disp bits ignored in short form, R4 scaling by 8
    issue("R3_R4 short ignores upper", 64'h100, 64'h1000, 64'h0, 5'd2, 32'hFFFF_FF05, 1'b0, 2'b01, 3'd3, 1'b0);
    chk("R3_R4 value", addr, 64'h1028);
    // R3 negative short offset, size 4
    issue("R3 neg short", 64'h0, 64'h1000, 64'h0, 5'd2, 32'h0000_00FF, 1'b0, 2'b01, 3'd2, 1'b0);
    chk("R3 neg value", addr, 64'hFFC);
    // R4 wide offset never scaled
    issue("R4 wide unscaled", 64'h0, 64'h1000, 64'h0, 5'd2, 32'h0000_0010, 1'b1, 2'b01, 3'd4, 1'b0);
    chk("R4 wide value", addr, 64'h1010);
    // R5 mode 00 with and without index, short flag ignored
    issue("R5 no index", 64'h4000, 64'h9999, 64'h77, 5'd31, 32'h0000_0180, 1'b0, 2'b00, 3'd3, 1'b0);
    chk("R5 no index value", addr, 64'h4180);
    issue("R5 with index", 64'h4000, 64'h9999, 64'h77, 5'd3, 32'hFFFF_FFF0, 1'b1, 2'b00, 3'd3, 1'b0);
    chk("R5 with index value", addr, 64'h4067);
    // R6 index not used
    issue("R6 base only", 64'h0, 64'h500, 64'hABCD, 5'd4, 32'd0, 1'b1, 2'b01, 3'd0, 1'b0);
    chk("R6 value", addr, 64'h500);
    // R7 id 31 still adds index
    issue("R7 id31 keeps index", 64'h0, 64'h500, 64'h20, 5'd31, 32'd4, 1'b1, 2'b10, 3'd0, 1'b0);
    chk("R7 value", addr, 64'h524);
    // R8 and R9: every size code
    for (int c = 0; c < 8; c++) begin
      issue("R8_R9 scaled index", 64'h0, 64'h0, 64'h3, 5'd1, 32'h1, 1'b0, 2'b11, 3'(c), 1'b0);
      chk("R9 size map", addr, 64'h4 << ((c >= 4) ? 4 : c));
    end
    // R10 branch ignores mode/base/index/size
    issue("R10 short branch", 64'h2000, 64'hDEAD, 64'hBEEF, 5'd1, 32'h0000_00FE, 1'b0, 2'b11, 3'd4, 1'b1);
    chk("R10 short value", addr, 64'h1FF8);
    issue("R10 wide branch", 64'h2000, 64'hDEAD, 64'hBEEF, 5'd1, 32'h0000_0100, 1'b1, 2'b10, 3'd1, 1'b1);
    chk("R10 wide value", addr, 64'h2400);
    // R11 wrap
    issue("R11 wrap", 64'h0, 64'hFFFF_FFFF_FFFF_FFF8, 64'h10, 5'd1, 32'h0, 1'b1, 2'b10, 3'd0, 1'b0);
    chk("R11 value", addr, 64'h8);

    // R2 hold when idle
    held = addr;
    in_valid = 1'b0; base = 64'h1234; ip = 64'h5678;
    @(negedge clk);
    chk("R2 idle valid", {63'd0, out_valid}, 64'd0);
    chk("R2 hold", addr, held);
    @(negedge clk);
    chk("R2 hold 2", addr, held);

    // random mix
    for (int n = 0; n < 400; n++) begin
      issue("R2_R3_R4_R5_R6_R7_R8_R10 random",
            {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
            5'($urandom_range(31)), $urandom, 1'($urandom), 2'($urandom), 3'($urandom),
            ($urandom_range(3) == 0));
    end

    in_valid = 1'b0;
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule